// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that a storage device and its host controller both support. The device side is described by its identify words: a field-valid word, three mode words (Ultra, multiword and single-word DMA, with supported modes in the low byte and the active mode in the high byte) and a legacy single-word mode byte. The host side gives one 8-bit mask per family. A cable-detect input, a device-type input, a host switch that forbids DMA on packet devices, and a requested ceiling mode complete the inputs.

A one-cycle `start_i` pulse captures all inputs. The result appears on `mode_o` together with a one-cycle `done_o` strobe and stays there until the next result. Mode codes use the usual ATA transfer-mode numbering: single-word DMA n is 0x10+n, multiword DMA n is 0x20+n, Ultra DMA n is 0x40+n, and 0x00 means no DMA.

The selection runs in three register stages: capture, per-family mask computation, then priority pick with clamping.

Top module: `dma_mode_selector`

## Requirements
- R1: While `rst` is high and after it is released, `done_o` is 0 and `mode_o` is 0x00 until the first result.
- R2: `done_o` is high for exactly one cycle, on the third rising edge after the edge that samples `start_i` high, and `mode_o` takes the new result on that same edge.
- R3: `mode_o` changes only on an edge that also raises `done_o`; input changes without a start pulse leave it unchanged.
- R4: Families are tried in the order Ultra (base 0x40), multiword (base 0x20), single-word (base 0x10). A family whose base is above the requested mode is skipped. The first family with a nonzero mask wins.
- R5: The Ultra family counts only when bit 2 of the field-valid word is 1. Its mask is the Ultra host mask ANDed with the low byte of the device Ultra word.
- R6: When the requested mode is above 0x42 and `cable80_i` is 0, bits 3 to 6 of the Ultra mask (Ultra modes 3 to 6) are cleared.
- R7: The multiword family counts only when bit 1 of the field-valid word is 1. Its mask is the multiword host mask ANDed with the low byte of the device multiword word.
- R8: The single-word mask is the single-word host mask ANDed with the device single-word low byte when field-valid bit 1 is 1. Otherwise it is the host mask ANDed with 0x03 for legacy byte 1, with 0x07 for legacy byte 2, and is zero for legacy byte 0 or above 2.
- R9: The chosen mode is the family base plus the index of the highest set bit of its mask, then lowered to the requested mode if it is larger.
- R10: When `is_disk_i` is 0 and `pkt_dma_off_i` is 1, the result is 0x00.
- R11: The result is 0x00 when field-valid bit 2 is 1 and the high bytes of both the Ultra and multiword device words are nonzero, or when bit 2 is 0, bit 1 is 1, and the high bytes of both the multiword and single-word device words are nonzero.
- R12: When no family that is tried has a nonzero mask, the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request; captures all inputs |
| id_valid_i | input | 16 | Device field-valid word (bits 1 and 2 used) |
| udma_dev_i | input | 16 | Device Ultra DMA word (low: supported, high: active) |
| mwdma_dev_i | input | 16 | Device multiword DMA word |
| swdma_dev_i | input | 16 | Device single-word DMA word |
| legacy_dma_i | input | 8 | Device legacy single-word mode number |
| udma_host_i | input | 8 | Host Ultra mode mask |
| mwdma_host_i | input | 8 | Host multiword mode mask |
| swdma_host_i | input | 8 | Host single-word mode mask |
| cable80_i | input | 1 | 1 when an 80-wire cable is detected |
| is_disk_i | input | 1 | 1 for a disk, 0 for a packet device |
| pkt_dma_off_i | input | 1 | Host forbids DMA on packet devices |
| req_mode_i | input | 8 | Requested ceiling mode code |
| done_o | output | 1 | One-cycle result strobe |
| mode_o | output | 8 | Selected mode code, 0x00 for no DMA |

## Verification
The clocked checks look back exactly three cycles from `done_o` to the start pulse and to the requested mode, so they assume inputs stay known and that `start_i` is a clean pulse sampled at a single edge. The result-code check assumes the requested mode lies within or above a family range, so clamping cannot produce a code outside the three families. Every directed scenario drives one isolated start pulse with stable, fully defined inputs and waits for the strobe before the next, keeping the stimulus inside these assumptions.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;
  localparam int MODE_W  = 8;
  localparam int MASK_W  = 8;
  localparam int ID_W    = 16;
  localparam int N_FAM   = 3;
  // family index: 0 single-word, 1 multiword, 2 Ultra
  localparam int FAM_SW  = 0;
  localparam int FAM_MW  = 1;
  localparam int FAM_UD  = 2;
  localparam logic [MODE_W-1:0] NO_DMA   = 8'h00;
  localparam logic [MODE_W-1:0] UDMA2    = 8'h42;
  localparam logic [MASK_W-1:0] UD_HIGH  = 8'h78;

  function automatic logic [MODE_W-1:0] fam_base(input int f);
    case (f)
      FAM_UD:  fam_base = 8'h40;
      FAM_MW:  fam_base = 8'h20;
      default: fam_base = 8'h10;
    endcase
  endfunction

  function automatic logic [2:0] top_bit(input logic [MASK_W-1:0] m);
    top_bit = 3'd0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) top_bit = i[2:0];
  endfunction
endpackage

// File: rtl/dma_legacy_mask.sv
module dma_legacy_mask
  import dma_mode_pkg::*;
(
  input  logic [7:0]        legacy_i,
  output logic [MASK_W-1:0] mask_o
);
  always_comb begin
    case (legacy_i)
      8'd1:    mask_o = 8'h03;
      8'd2:    mask_o = 8'h07;
      default: mask_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_family_mask.sv
module dma_family_mask
  import dma_mode_pkg::*;
#(
  parameter logic [MODE_W-1:0] BASE = 8'h10
) (
  input  logic              gate_i,
  input  logic [MASK_W-1:0] dev_i,
  input  logic [MASK_W-1:0] fallback_i,
  input  logic [MASK_W-1:0] host_i,
  input  logic              strip_i,
  input  logic [MODE_W-1:0] req_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              tried_o
);
  logic [MASK_W-1:0] src;
  always_comb begin
    src     = gate_i ? dev_i : fallback_i;
    mask_o  = src & host_i & ~(strip_i ? UD_HIGH : '0);
    tried_o = (req_i >= BASE);
  end
endmodule

// File: rtl/dma_mode_pick.sv
module dma_mode_pick
  import dma_mode_pkg::*;
(
  input  logic [N_FAM-1:0][MASK_W-1:0] mask_i,
  input  logic [N_FAM-1:0]             tried_i,
  input  logic                         refuse_i,
  input  logic [MODE_W-1:0]            req_i,
  output logic [MODE_W-1:0]            mode_o
);
  logic found;
  always_comb begin
    mode_o = NO_DMA;
    found  = 1'b0;
    if (!refuse_i) begin
      for (int f = N_FAM - 1; f >= 0; f--) begin
        if (!found && tried_i[f] && (|mask_i[f])) begin
          mode_o = fam_base(f) | {5'd0, top_bit(mask_i[f])};
          found  = 1'b1;
        end
      end
      if (mode_o > req_i) mode_o = req_i;
    end
  end
endmodule

// File: rtl/dma_mode_selector.sv
module dma_mode_selector
  import dma_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ID_W-1:0]   id_valid_i,
  input  logic [ID_W-1:0]   udma_dev_i,
  input  logic [ID_W-1:0]   mwdma_dev_i,
  input  logic [ID_W-1:0]   swdma_dev_i,
  input  logic [7:0]        legacy_dma_i,
  input  logic [MASK_W-1:0] udma_host_i,
  input  logic [MASK_W-1:0] mwdma_host_i,
  input  logic [MASK_W-1:0] swdma_host_i,
  input  logic              cable80_i,
  input  logic              is_disk_i,
  input  logic              pkt_dma_off_i,
  input  logic [MODE_W-1:0] req_mode_i,
  output logic              done_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int HB = ID_W / 2;

  // stage 0: capture
  logic              v0;
  logic [ID_W-1:0]   fv_q, ud_q, mw_q, sw_q;
  logic [7:0]        leg_q;
  logic [MASK_W-1:0] udh_q, mwh_q, swh_q;
  logic              cab_q, disk_q, pko_q;
  logic [MODE_W-1:0] req0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0;
      fv_q <= '0; ud_q <= '0; mw_q <= '0; sw_q <= '0; leg_q <= '0;
      udh_q <= '0; mwh_q <= '0; swh_q <= '0;
      cab_q <= 1'b0; disk_q <= 1'b0; pko_q <= 1'b0; req0_q <= '0;
    end else begin
      v0 <= start_i;
      if (start_i) begin
        fv_q  <= id_valid_i;  ud_q  <= udma_dev_i;
        mw_q  <= mwdma_dev_i; sw_q  <= swdma_dev_i;
        leg_q <= legacy_dma_i;
        udh_q <= udma_host_i; mwh_q <= mwdma_host_i; swh_q <= swdma_host_i;
        cab_q <= cable80_i; disk_q <= is_disk_i; pko_q <= pkt_dma_off_i;
        req0_q <= req_mode_i;
      end
    end
  end

  // per-family operands
  logic [MASK_W-1:0] legacy_mask;
  logic [N_FAM-1:0]              f_gate, f_strip, f_tried;
  logic [N_FAM-1:0][MASK_W-1:0]  f_dev, f_fb, f_host, f_mask;
  logic corrupt, refuse;

  dma_legacy_mask u_legacy (.legacy_i(leg_q), .mask_o(legacy_mask));

  always_comb begin
    f_gate[FAM_UD]  = fv_q[2];
    f_gate[FAM_MW]  = fv_q[1];
    f_gate[FAM_SW]  = fv_q[1];
    f_dev[FAM_UD]   = ud_q[MASK_W-1:0];
    f_dev[FAM_MW]   = mw_q[MASK_W-1:0];
    f_dev[FAM_SW]   = sw_q[MASK_W-1:0];
    f_fb[FAM_UD]    = '0;
    f_fb[FAM_MW]    = '0;
    f_fb[FAM_SW]    = legacy_mask;
    f_host[FAM_UD]  = udh_q;
    f_host[FAM_MW]  = mwh_q;
    f_host[FAM_SW]  = swh_q;
    f_strip[FAM_UD] = (req0_q > UDMA2) && !cab_q;
    f_strip[FAM_MW] = 1'b0;
    f_strip[FAM_SW] = 1'b0;
    if (fv_q[2])
      corrupt = (|ud_q[ID_W-1:HB]) && (|mw_q[ID_W-1:HB]);
    else if (fv_q[1])
      corrupt = (|mw_q[ID_W-1:HB]) && (|sw_q[ID_W-1:HB]);
    else
      corrupt = 1'b0;
    refuse = corrupt || (!disk_q && pko_q);
  end

  for (genvar g = 0; g < N_FAM; g++) begin : g_fam
    dma_family_mask #(.BASE(fam_base(g))) u_fam (
      .gate_i    (f_gate[g]),
      .dev_i     (f_dev[g]),
      .fallback_i(f_fb[g]),
      .host_i    (f_host[g]),
      .strip_i   (f_strip[g]),
      .req_i     (req0_q),
      .mask_o    (f_mask[g]),
      .tried_o   (f_tried[g])
    );
  end

  // stage 1: masks
  logic                         v1, refuse_q;
  logic [N_FAM-1:0][MASK_W-1:0] mask_q;
  logic [N_FAM-1:0]             tried_q;
  logic [MODE_W-1:0]            req1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; refuse_q <= 1'b0; mask_q <= '0; tried_q <= '0; req1_q <= '0;
    end else begin
      v1 <= v0;
      if (v0) begin
        refuse_q <= refuse;
        mask_q   <= f_mask;
        tried_q  <= f_tried;
        req1_q   <= req0_q;
      end
    end
  end

  // stage 2: pick and register result
  logic [MODE_W-1:0] pick_mode;
  dma_mode_pick u_pick (
    .mask_i  (mask_q),
    .tried_i (tried_q),
    .refuse_i(refuse_q),
    .req_i   (req1_q),
    .mode_o  (pick_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      mode_o <= NO_DMA;
    end else begin
      done_o <= v1;
      if (v1) mode_o <= pick_mode;
    end
  end

  // R2
  done_lat_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i, 3));
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_o) |-> done_o);
  // R9
  req_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mode_o <= $past(req_mode_i, 3)));
  // R10
  pkt_off_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(!is_disk_i && pkt_dma_off_i, 3)) |-> (mode_o == NO_DMA));
  // R4
  fam_code_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mode_o == NO_DMA || mode_o[7:4] == 4'h1 ||
                mode_o[7:4] == 4'h2 || mode_o[7:4] == 4'h4));
endmodule

// File: tb/dma_mode_selector_test.sv
module dma_mode_selector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] fv = '0, ud = '0, mw = '0, sw = '0;
  logic [7:0]  leg = '0, udh = '0, mwh = '0, swh = '0, req = '0;
  logic        cab = 1'b0, disk = 1'b1, pko = 1'b0;
  logic        done;
  logic [7:0]  mode;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_mode_selector uut (
    .clk(clk), .rst(rst), .start_i(start),
    .id_valid_i(fv), .udma_dev_i(ud), .mwdma_dev_i(mw), .swdma_dev_i(sw),
    .legacy_dma_i(leg), .udma_host_i(udh), .mwdma_host_i(mwh), .swdma_host_i(swh),
    .cable80_i(cab), .is_disk_i(disk), .pkt_dma_off_i(pko),
    .req_mode_i(req), .done_o(done), .mode_o(mode)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic baseline();
    fv = 16'h0006; ud = 16'h007F; mw = 16'h0007; sw = 16'h0007; leg = 8'd0;
    udh = 8'h7F; mwh = 8'h07; swh = 8'h07;
    cab = 1'b1; disk = 1'b1; pko = 1'b0; req = 8'h46;
  endtask

  // drive a start pulse, check strobe timing (R2) and the result
  task automatic run(string tag, logic [7:0] exp);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R2 early"}, {7'd0, done}, 8'h00);
    @(negedge clk);
    check({tag, " R2 early"}, {7'd0, done}, 8'h00);
    @(negedge clk);
    check({tag, " R2 strobe"}, {7'd0, done}, 8'h01);
    check(tag, mode, exp);
    @(negedge clk);
    check({tag, " R2 single"}, {7'd0, done}, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 done", {7'd0, done}, 8'h00);
    check("R1 mode", mode, 8'h00);
  endtask

  task automatic t_udma_full();
    baseline(); run("R5 R9 udma6", 8'h46);
    baseline(); udh = 8'h1F; run("R5 host limit", 8'h44);
    baseline(); req = 8'h44; run("R9 clamp", 8'h44);
  endtask

  task automatic t_cable();
    baseline(); cab = 1'b0; run("R6 no cable", 8'h42);
    baseline(); cab = 1'b0; ud = 16'h0078; run("R6 only high modes", 8'h22);
  endtask

  task automatic t_order();
    baseline(); fv = 16'h0002; run("R5 R7 udma gated", 8'h22);
    baseline(); req = 8'h21; run("R4 below udma base", 8'h21);
    baseline(); req = 8'h12; run("R4 below mw base", 8'h12);
    baseline(); req = 8'h0F; run("R4 below all bases", 8'h00);
    baseline(); mw = 16'h0000; sw = 16'h0003; fv = 16'h0002;
    run("R8 R4 sw via fv1", 8'h11);
  endtask

  task automatic t_legacy();
    baseline(); fv = 16'h0000; leg = 8'd2; run("R8 legacy 2", 8'h12);
    baseline(); fv = 16'h0000; leg = 8'd1; run("R8 legacy 1", 8'h11);
    baseline(); fv = 16'h0000; leg = 8'd3; run("R8 legacy 3", 8'h00);
    baseline(); fv = 16'h0000; leg = 8'd2; swh = 8'h01; run("R8 legacy host", 8'h10);
  endtask

  task automatic t_refuse();
    baseline(); disk = 1'b0; pko = 1'b1; run("R10 packet off", 8'h00);
    baseline(); disk = 1'b0; run("R10 packet on", 8'h46);
    baseline(); disk = 1'b1; pko = 1'b1; run("R10 disk ignores", 8'h46);
    baseline(); ud = 16'h207F; mw = 16'h0407; run("R11 ud+mw active", 8'h00);
    baseline(); fv = 16'h0002; mw = 16'h0407; sw = 16'h0407; run("R11 mw+sw active", 8'h00);
    baseline(); fv = 16'h0002; mw = 16'h0407; run("R11 only mw active", 8'h22);
  endtask

  task automatic t_empty();
    baseline(); udh = 8'h00; mwh = 8'h00; swh = 8'h00; run("R12 no masks", 8'h00);
  endtask

  task automatic t_hold();
    baseline(); run("R3 setup", 8'h46);
    fv = 16'h0000; req = 8'h00; disk = 1'b0; pko = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 held", mode, 8'h46);
    check("R3 no strobe", {7'd0, done}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_udma_full();
    t_cable();
    t_order();
    t_legacy();
    t_refuse();
    t_empty();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule